// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command interface of a byte-wide parallel NOR flash. It watches bus write cycles and recognises the fixed address/data key handshakes that precede every change to the array: byte program, sector erase, chip erase and identification (autoselect) entry. A sequence that goes off track returns the interface to plain read mode and leaves the array alone.

Once a program or erase is accepted, an embedded operation runs for a fixed number of clock cycles. While it runs, every read returns a status byte instead of array data. Bit 7 is the inverse of the final bit 7 of the targeted data, and bit 6 flips on each successive read. One sector, at the top or the bottom of the address space as chosen by a parameter, is the boot sector. While the protect strap is high, that sector cannot be programmed or erased. The storage is a small behavioural register array, and both operation latencies are parameters.

The bus is synchronous. Each clock cycle in which the strobes are asserted counts as one access, and read data appears on the cycle after the read is sampled.

Top module: `nor_cmd_decoder`

## Requirements
- R1: Every command starts with two key writes: AAh to address 05555h, then 55h to address 02AAAh. All address bits are compared, and the upper bits must be zero. A byte program then needs A0h written to 05555h, followed by one write that carries the target address and data.
- R2: A program leaves the addressed byte equal to (old byte AND written data). No other byte changes.
- R3: A chip erase takes six writes: AAh@05555h, 55h@02AAAh, 80h@05555h, AAh@05555h, 55h@02AAAh, 10h@05555h. When it completes, every byte reads FFh, except the boot sector while it is protected (see R10).
- R4: A sector erase uses the same first five writes, then 30h written to any address in the sector. A sector is address bits [MEM_AW-1:SECT_AW]. Only the bytes of that sector become FFh.
- R5: While an operation runs, a read returns bit 7 equal to the inverse of the final bit 7. The final bit 7 is (old AND data) bit 7 for a program and 1 for an erase. Bits 5:0 are 0. After completion, reads return array data.
- R6: While an operation runs, bit 6 of the status is 0 on the first read after the start and changes value on every further read.
- R7: A write that does not match the expected next step returns the decoder to read mode. It does not modify the array, and it is not reused as the first key write.
- R8: A read is a cycle with ce_n=0, oe_n=0 and we_n=1, and its byte appears on rdata one cycle later. A write is a cycle with ce_n=0 and we_n=0. rdata holds its value when no read takes place.
- R9: AAh, 55h, then 90h to 05555h enters identification mode. In this mode, reads select by address bits [1:0]: 0 returns MFR_ID, 1 returns DEV_ID, 2 returns 01h if the boot sector is protected and 00h if not, and 3 returns 00h. Any write leaves the mode.
- R10: The boot sector is the highest-numbered sector when BOOT_AT_TOP=1 and sector 0 otherwise. While boot_protect=1, a program or sector erase aimed at it never becomes busy and changes nothing, and a chip erase leaves it unchanged.
- R11: Writes made while an operation runs are ignored and do not advance any sequence.
- R12: An accepted operation is busy for PROG_CYCLES (program) or ERASE_CYCLES (erase) cycles after its final write. A read sampled in the last busy cycle still returns status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the array resets to FFh |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| boot_protect | input | 1 | Boot sector protect strap |
| rdata | output | 8 | Read data, registered |

## Verification
The two functions that can meet in one cycle are a status read and the completion of the embedded operation. In the last busy cycle, the array update and the end of busy share the same edge on which a read is sampled. The bench provokes this by issuing an unbroken run of reads right after the final command write, with exactly PROG_CYCLES or ERASE_CYCLES reads in the run. It expects every read in that run, including the one sampled on the completion edge, to return the toggling status byte, and the very next read to return the updated array byte.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  CMD_PROG   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE  = 8'h80;
    localparam logic [7:0]  CMD_IDENT  = 8'h90;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_SECT   = 8'h30;

    typedef enum logic [2:0] {
        SQ_READ,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG,
        SQ_ERA1,
        SQ_ERA2,
        SQ_ERA3,
        SQ_IDENT
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [7:0] data;
    } op_cmd_t;

    function automatic logic [7:0] busy_status(input logic final_msb, input logic tog);
        return {~final_msb, tog, 6'b000000};
    endfunction

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output op_cmd_t           cmd_o,
    output logic              cmd_v_o,
    output logic              ident_o
);

    localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(KEY_ADDR_B);

    seq_state_e st_q, st_d;
    logic hit_a, hit_b, at_a, take;

    assign at_a  = (addr == ADDR_A);
    assign hit_a = at_a && (wdata == KEY_DATA_A);
    assign hit_b = (addr == ADDR_B) && (wdata == KEY_DATA_B);
    assign take  = wr_stb && !busy;

    always_comb begin
        st_d       = st_q;
        cmd_v_o    = 1'b0;
        cmd_o.kind = OP_NONE;
        cmd_o.data = wdata;
        if (take) begin
            case (st_q)
                SQ_READ: st_d = hit_a ? SQ_KEY1 : SQ_READ;
                SQ_KEY1: st_d = hit_b ? SQ_KEY2 : SQ_READ;
                SQ_KEY2: begin
                    st_d = SQ_READ;
                    if (at_a) begin
                        case (wdata)
                            CMD_PROG:  st_d = SQ_PROG;
                            CMD_ERASE: st_d = SQ_ERA1;
                            CMD_IDENT: st_d = SQ_IDENT;
                            default:   st_d = SQ_READ;
                        endcase
                    end
                end
                SQ_PROG: begin
                    cmd_v_o    = 1'b1;
                    cmd_o.kind = OP_PROG;
                    st_d       = SQ_READ;
                end
                SQ_ERA1: st_d = hit_a ? SQ_ERA2 : SQ_READ;
                SQ_ERA2: st_d = hit_b ? SQ_ERA3 : SQ_READ;
                SQ_ERA3: begin
                    st_d = SQ_READ;
                    if (at_a && wdata == CMD_CHIP) begin
                        cmd_v_o    = 1'b1;
                        cmd_o.kind = OP_CHIP;
                    end else if (wdata == CMD_SECT) begin
                        cmd_v_o    = 1'b1;
                        cmd_o.kind = OP_SECT;
                    end
                end
                SQ_IDENT: st_d = SQ_READ;
                default:  st_d = SQ_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_READ;
        else     st_q <= st_d;
    end

    assign ident_o = (st_q == SQ_IDENT);

    // R7: a wrong second key write drops back to read mode
    assert_break_to_read_R7: assert property (@(posedge clk) disable iff (rst)
        (take && st_q == SQ_KEY1 && !hit_b) |=> (st_q == SQ_READ));

    // R1: the program data phase is reached only through the key handshake
    assert_prog_after_keys_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_PROG) |-> ($past(st_q) == SQ_KEY2 || $past(st_q) == SQ_PROG));

    // R11: no sequence progress while an operation runs
    assert_hold_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> (st_q == $past(st_q)));

endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer
    import nor_cmd_pkg::*;
#(
    parameter int MEM_AW       = 8,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_v,
    input  op_cmd_t           cmd,
    input  logic [MEM_AW-1:0] cmd_addr,
    input  logic              blocked,
    input  logic              old_msb,
    input  logic              rd_stb,
    output logic              busy_o,
    output logic              done_o,
    output op_kind_e          run_kind_o,
    output logic [MEM_AW-1:0] run_addr_o,
    output logic [7:0]        run_data_o,
    output logic [7:0]        status_o
);

    localparam int MAX_LAT = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW      = $clog2(MAX_LAT + 1);

    logic          busy_q, tog_q, final_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign accept = cmd_v && !blocked && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            tog_q      <= 1'b0;
            final_q    <= 1'b0;
            cnt_q      <= '0;
            run_kind_o <= OP_NONE;
            run_addr_o <= '0;
            run_data_o <= '0;
        end else if (!busy_q) begin
            if (accept) begin
                busy_q     <= 1'b1;
                tog_q      <= 1'b0;
                run_kind_o <= cmd.kind;
                run_addr_o <= cmd_addr;
                run_data_o <= cmd.data;
                if (cmd.kind == OP_PROG) begin
                    cnt_q   <= CW'(PROG_CYCLES - 1);
                    final_q <= old_msb & cmd.data[7];
                end else begin
                    cnt_q   <= CW'(ERASE_CYCLES - 1);
                    final_q <= 1'b1;
                end
            end
        end else begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
            if (rd_stb) tog_q <= ~tog_q;
        end
    end

    assign busy_o   = busy_q;
    assign done_o   = busy_q && (cnt_q == '0);
    assign status_o = busy_status(final_q, tog_q);

    // R10: a command aimed at the protected boot sector never goes busy
    assert_blocked_stays_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_v && blocked && !busy_q) |=> !busy_q);

    // R12: busy begins only from an accepted command
    assert_start_from_cmd_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(cmd_v && !blocked));

    // R12: the countdown never exceeds the longest latency
    assert_count_in_range_R12: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < CW'(MAX_LAT)));

endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array
    import nor_cmd_pkg::*;
#(
    parameter int MEM_AW  = 8,
    parameter int SECT_AW = 6,
    parameter logic [MEM_AW-SECT_AW-1:0] BOOT_SECT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    input  logic              done,
    input  op_kind_e          kind,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              boot_protect
);

    localparam int DEPTH     = 1 << MEM_AW;
    localparam int SECT_W    = MEM_AW - SECT_AW;
    localparam int BOOT_BASE = int'(BOOT_SECT) << SECT_AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] old_wr;

    function automatic logic [SECT_W-1:0] sect_of(input int i);
        logic [MEM_AW-1:0] a;
        a = MEM_AW'(i);
        return a[MEM_AW-1:SECT_AW];
    endfunction

    assign rd_byte = mem[rd_addr];
    assign old_wr  = mem[wr_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (done) begin
            case (kind)
                OP_PROG: mem[wr_addr] <= old_wr & wr_data;
                OP_SECT: begin
                    for (int i = 0; i < DEPTH; i++)
                        if (sect_of(i) == wr_addr[MEM_AW-1:SECT_AW]) mem[i] <= 8'hFF;
                end
                OP_CHIP: begin
                    for (int i = 0; i < DEPTH; i++)
                        if (!(boot_protect && sect_of(i) == BOOT_SECT)) mem[i] <= 8'hFF;
                end
                default: ;
            endcase
        end
    end

    // R2: programming only clears bits of the addressed byte
    assert_prog_and_R2: assert property (@(posedge clk) disable iff (rst)
        (done && kind == OP_PROG) |=> (mem[$past(wr_addr)] == $past(old_wr & wr_data)));

    // R10: chip erase keeps a protected boot sector
    assert_boot_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (done && kind == OP_CHIP && boot_protect) |=> (mem[BOOT_BASE] == $past(mem[BOOT_BASE])));

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int         ADDR_W       = 19,
    parameter int         MEM_AW       = 8,
    parameter int         SECT_AW      = 6,
    parameter int         BOOT_AT_TOP  = 0,
    parameter int         PROG_CYCLES  = 8,
    parameter int         ERASE_CYCLES = 20,
    parameter logic [7:0] MFR_ID       = 8'h40,
    parameter logic [7:0] DEV_ID       = 8'hA4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              boot_protect,
    output logic [7:0]        rdata
);

    localparam int SECT_W = MEM_AW - SECT_AW;
    localparam logic [SECT_W-1:0] BOOT_SECT = (BOOT_AT_TOP != 0) ? {SECT_W{1'b1}} : {SECT_W{1'b0}};

    logic              wr_stb, rd_stb, busy, done, ident, cmd_v, blocked, stat_rd_q;
    logic [MEM_AW-1:0] mem_addr, run_addr;
    logic [7:0]        rd_byte, run_data, status, id_byte;
    op_cmd_t           cmd;
    op_kind_e          run_kind;

    assign wr_stb   = !ce_n && !we_n;
    assign rd_stb   = !ce_n && !oe_n && we_n;
    assign mem_addr = addr[MEM_AW-1:0];
    assign blocked  = boot_protect && (mem_addr[MEM_AW-1:SECT_AW] == BOOT_SECT) &&
                      (cmd.kind == OP_PROG || cmd.kind == OP_SECT);

    nor_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .busy    (busy),
        .addr    (addr),
        .wdata   (wdata),
        .cmd_o   (cmd),
        .cmd_v_o (cmd_v),
        .ident_o (ident)
    );

    nor_op_timer #(
        .MEM_AW      (MEM_AW),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .cmd_v      (cmd_v),
        .cmd        (cmd),
        .cmd_addr   (mem_addr),
        .blocked    (blocked),
        .old_msb    (rd_byte[7]),
        .rd_stb     (rd_stb),
        .busy_o     (busy),
        .done_o     (done),
        .run_kind_o (run_kind),
        .run_addr_o (run_addr),
        .run_data_o (run_data),
        .status_o   (status)
    );

    nor_byte_array #(
        .MEM_AW   (MEM_AW),
        .SECT_AW  (SECT_AW),
        .BOOT_SECT(BOOT_SECT)
    ) u_array (
        .clk          (clk),
        .rst          (rst),
        .rd_addr      (mem_addr),
        .rd_byte      (rd_byte),
        .done         (done),
        .kind         (run_kind),
        .wr_addr      (run_addr),
        .wr_data      (run_data),
        .boot_protect (boot_protect)
    );

    always_comb begin
        case (addr[1:0])
            2'd0:    id_byte = MFR_ID;
            2'd1:    id_byte = DEV_ID;
            2'd2:    id_byte = {7'b0000000, boot_protect};
            default: id_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= 8'h00;
            stat_rd_q <= 1'b0;
        end else begin
            stat_rd_q <= rd_stb && busy;
            if (rd_stb) begin
                if (busy)       rdata <= status;
                else if (ident) rdata <= id_byte;
                else            rdata <= rd_byte;
            end
        end
    end

    // R6: back-to-back status reads alternate bit 6
    assert_bit6_alternates_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && busy && stat_rd_q) |=> (rdata[6] != $past(rdata[6])));

    // R5: erase status reads show bit 7 low
    assert_erase_msb_low_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && busy && run_kind != OP_PROG) |=> (rdata[7] == 1'b0));

    // R8: read data holds without a read
    assert_rdata_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rdata));

endmodule

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst, ce_n, oe_n, we_n, prot;
    logic [18:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;

    always #5 clk = ~clk;

    nor_cmd_decoder u_nor_cmd_decoder (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .boot_protect(prot), .rdata(rdata)
    );

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    localparam int PROG_N  = 8;
    localparam int ERASE_N = 20;

    function automatic logic [7:0] stat(input logic final_msb, input int k);
        return {~final_msb, logic'(k % 2), 6'b000000};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [18:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); ce_n = 0; we_n = 1; oe_n = 0; addr = a;
        exp_q.push_back('{e, tag});
    endtask

    task automatic keys();
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
    endtask

    task automatic prog(input logic [18:0] a, input logic [7:0] d);
        keys(); wr(19'h05555, 8'hA0); wr(a, d);
    endtask

    task automatic erase(input logic [18:0] a, input logic [7:0] c);
        keys(); wr(19'h05555, 8'h80); keys(); wr(a, c);
    endtask

    task automatic poll(input int n, input logic final_msb, input string tag);
        for (int k = 0; k < n; k++) rd(19'h0, stat(final_msb, k), tag);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            logic hit;
            exp_t e;
            @(posedge clk);
            hit = !ce_n && !oe_n && we_n && !rst;
            @(negedge clk);
            if (hit) begin
                e = exp_q.pop_front();
                n_cmp++;
                if (rdata !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", e.tag, rdata, e.val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1; ce_n = 1; oe_n = 1; we_n = 1; prot = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        n_cmp++;
        if (rdata !== 8'h00) begin
            n_bad++;
            $display("FAIL R8 reset rdata: actual %02h expected 00", rdata);
        end
        rd(19'h00040, 8'hFF, "R8 erased after reset");

        // R1 R5 R6 R12: program, status run ending on the completion edge
        prog(19'h00045, 8'h5A);
        poll(PROG_N, 1'b0, "R5 R6 R12 program status");
        rd(19'h00045, 8'h5A, "R1 R12 program data");

        // R2: second program ANDs
        prog(19'h00045, 8'hF0); idle(PROG_N + 2);
        rd(19'h00045, 8'h5A & 8'hF0, "R2 and result");
        rd(19'h00046, 8'hFF, "R2 neighbour untouched");

        // boot sector content for later protection checks
        prog(19'h00005, 8'h33); idle(PROG_N + 2);
        rd(19'h00005, 8'h33, "R1 boot sector program");

        // R7: broken sequences
        wr(19'h05555, 8'hAA); wr(19'h02AAB, 8'h55); wr(19'h05555, 8'hA0); wr(19'h00047, 8'h00);
        rd(19'h00047, 8'hFF, "R7 bad key address");
        rd(19'h00047, 8'hFF, "R7 no busy after break");
        keys(); wr(19'h05555, 8'h77); wr(19'h00048, 8'h00);
        rd(19'h00048, 8'hFF, "R7 bad command byte");
        wr(19'h45555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h00049, 8'h00);
        rd(19'h00049, 8'hFF, "R1 upper address bits must be zero");

        // R9: identification mode
        keys(); wr(19'h05555, 8'h90);
        rd(19'h00002, 8'h00, "R9 boot unprotected");
        @(negedge clk); prot = 1; ce_n = 1; we_n = 1; oe_n = 1;
        rd(19'h00002, 8'h01, "R9 boot protected");
        rd(19'h00000, 8'h40, "R9 manufacturer id");
        rd(19'h00001, 8'hA4, "R9 device id");
        wr(19'h00000, 8'hF0);
        rd(19'h00045, 8'h50, "R9 exit to array reads");

        // R10: protected boot sector (sector 0, bottom)
        prog(19'h00005, 8'h00);
        rd(19'h00005, 8'h33, "R10 protected program ignored");
        erase(19'h00010, 8'h30);
        rd(19'h00005, 8'h33, "R10 protected sector erase ignored");

        // R11: writes during busy ignored
        prog(19'h00080, 8'h7F);
        prog(19'h00081, 8'h00);
        idle(PROG_N + 2);
        rd(19'h00081, 8'hFF, "R11 busy writes ignored");
        rd(19'h00080, 8'h7F, "R11 running program kept");

        // R4: sector erase of sector 1
        erase(19'h00044, 8'h30);
        poll(ERASE_N, 1'b1, "R4 R5 R6 sector erase status");
        rd(19'h00045, 8'hFF, "R4 sector erased");
        rd(19'h00080, 8'h7F, "R4 other sector kept");
        rd(19'h00005, 8'h33, "R4 boot sector kept");

        // R3 R10: chip erase with protection, then without
        erase(19'h05555, 8'h10);
        poll(ERASE_N, 1'b1, "R3 R5 chip erase status");
        rd(19'h00080, 8'hFF, "R3 chip erase");
        rd(19'h00005, 8'h33, "R10 chip erase keeps boot");
        @(negedge clk); prot = 0; ce_n = 1; we_n = 1; oe_n = 1;
        erase(19'h05555, 8'h10); idle(ERASE_N + 2);
        rd(19'h00005, 8'hFF, "R3 chip erase unprotected");
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule